// File: doc/BRIEF.md
# Time-Slot Scheduled Guaranteed-Throughput Router

This block forwards guaranteed-throughput traffic between a set of input and output ports of equal width. It uses neither packet headers nor arbitration. A free-running slot counter advances once per clock and wraps at the schedule length. A programmable schedule holds one entry per slot and per output. Each entry names the input that feeds that output in that slot, together with a valid flag. Every input word is stored for exactly one slot and then forwarded. The route is chosen by the schedule entry of the slot in which the word arrived. Because each output is owned by at most one input per slot, two flows can never compete for a link.

Software or a connection manager fills the schedule at run time through a single-entry write port. A write that would take an output already promised to a different input in that slot is refused. The refusal is flagged on an error output and the write is not applied. Clearing an entry is always allowed. One input may drive several outputs in the same slot (multicast).

Top module: `tdm_gt_router`

## Requirements
- R1: After reset `slot_o` is 0. It then increases by one on every clock and returns from SLOTS-1 (default 7) to 0.
- R2: A word present on input i with its valid bit high in slot t appears on every output o in slot t+1, provided that the schedule entry (t, o) is valid and names input i. In slot t+1 the output's valid bit is high and its data equals the word.
- R3: In slot t+1, an output whose schedule entry for slot t is invalid drives valid low and data all zeros.
- R4: In slot t+1, an output whose entry for slot t is valid, but whose named input had its valid bit low in slot t, drives valid low and data all zeros.
- R5: A write with `cfg_en_i`=1 is applied when the addressed entry is invalid or already names the same input. The entry then routes from the next cycle on, and `cfg_err_o` stays 0.
- R6: A write with `cfg_en_i`=1 to a valid entry that names a different input is refused. `cfg_err_o` is 1 in the cycle after the write, and the entry keeps its old route.
- R7: A write with `cfg_en_i`=0 always invalidates the addressed entry and never raises `cfg_err_o`.
- R8: Several outputs may name the same input in one slot, and each of them then carries that input's word.
- R9: After reset every schedule entry is invalid, so all outputs are idle whatever the inputs carry.
- R10: `cfg_err_o` is 0 in any cycle that does not directly follow a refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Per-input word valid |
| in_data_i | input | N_PORTS*DATA_W | Input words, input i in bits [i*DATA_W +: DATA_W] |
| out_valid_o | output | N_PORTS | Per-output word valid |
| out_data_o | output | N_PORTS*DATA_W | Output words, output o in bits [o*DATA_W +: DATA_W], zero when idle |
| slot_o | output | SLOT_W | Current slot number |
| cfg_we_i | input | 1 | Schedule write strobe |
| cfg_slot_i | input | SLOT_W | Slot of the addressed entry |
| cfg_out_i | input | IDX_W | Output of the addressed entry |
| cfg_in_i | input | IDX_W | Input to be named by the entry |
| cfg_en_i | input | 1 | 1 sets the route, 0 clears the entry |
| cfg_err_o | output | 1 | Refused write, one cycle after the strobe |

## Verification
The hardest state to reach is a refused write. It can only occur once an entry already holds a route, and proving that the refusal left the route intact takes live traffic through that exact slot. The bench first programs a rotating permutation into every slot and output. It then walks every entry with a write that names a different input and expects a refusal each time. After that it pushes words through all slots and checks that the outputs still follow the original permutation. Clearing, re-routing and multicast in one slot are exercised the same way, with the expected outputs computed from a model of the schedule held in the bench.

// File: rtl/gt_pkg.sv
package gt_pkg;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_SET,
    WR_CLR,
    WR_REJECT
  } wr_op_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gt_slot_counter.sv
module gt_slot_counter #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o
);

  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q == LastSlot) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o = cnt_q;

endmodule

// File: rtl/gt_in_stage.sv
module gt_in_stage #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SLOT_W  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  input  logic [N_PORTS*DATA_W-1:0]   in_data_i,
  input  logic [SLOT_W-1:0]           slot_i,
  output logic [N_PORTS-1:0]          st_valid_o,
  output logic [N_PORTS*DATA_W-1:0]   st_data_o,
  output logic [SLOT_W-1:0]           st_slot_o
);

  // Word and its arrival slot travel together; the tag selects the route.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_valid_o <= '0;
      st_data_o  <= '0;
      st_slot_o  <= '0;
    end else begin
      st_valid_o <= in_valid_i;
      st_data_o  <= in_data_i;
      st_slot_o  <= slot_i;
    end
  end

endmodule

// File: rtl/gt_slot_table.sv
module gt_slot_table
  import gt_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned SLOT_W  = 3,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [SLOT_W-1:0]          wr_slot_i,
  input  logic [IDX_W-1:0]           wr_out_i,
  input  logic [IDX_W-1:0]           wr_in_i,
  input  logic                       wr_set_i,
  output logic                       wr_err_o,
  input  logic [SLOT_W-1:0]          rd_slot_i,
  output logic [N_PORTS-1:0]         rd_vld_o,
  output logic [N_PORTS*IDX_W-1:0]   rd_idx_o
);

  logic [N_PORTS-1:0] vld_q [SLOTS];
  logic [IDX_W-1:0]   idx_q [SLOTS][N_PORTS];
  logic               err_q;

  logic               cur_vld;
  logic [IDX_W-1:0]   cur_idx;
  logic               in_ok;
  wr_op_e             op;

  // Range check only exists when the index field can exceed the port count.
  generate
    if (N_PORTS == (1 << IDX_W)) begin : g_full_range
      assign in_ok = 1'b1;
    end else begin : g_part_range
      assign in_ok = (int'(wr_in_i) < int'(N_PORTS));
    end
  endgenerate

  always_comb begin
    cur_vld = vld_q[wr_slot_i][wr_out_i];
    cur_idx = idx_q[wr_slot_i][wr_out_i];
    if (!wr_en_i)                                   op = WR_IDLE;
    else if (!wr_set_i)                             op = WR_CLR;
    else if (!in_ok || (cur_vld && cur_idx != wr_in_i)) op = WR_REJECT;
    else                                            op = WR_SET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(SLOTS); s++) begin
        vld_q[s] <= '0;
        for (int o = 0; o < int'(N_PORTS); o++) idx_q[s][o] <= '0;
      end
      err_q <= 1'b0;
    end else begin
      unique case (op)
        WR_SET: begin
          vld_q[wr_slot_i][wr_out_i] <= 1'b1;
          idx_q[wr_slot_i][wr_out_i] <= wr_in_i;
        end
        WR_CLR:  vld_q[wr_slot_i][wr_out_i] <= 1'b0;
        default: ;
      endcase
      err_q <= (op == WR_REJECT);
    end
  end

  assign wr_err_o = err_q;

  generate
    for (genvar o = 0; o < int'(N_PORTS); o++) begin : g_rd
      assign rd_vld_o[o]                   = vld_q[rd_slot_i][o];
      assign rd_idx_o[o*IDX_W +: IDX_W]    = idx_q[rd_slot_i][o];
    end
  endgenerate

endmodule

// File: rtl/gt_xbar.sv
module gt_xbar #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [N_PORTS-1:0]          st_valid_i,
  input  logic [N_PORTS*DATA_W-1:0]   st_data_i,
  input  logic [N_PORTS-1:0]          sel_vld_i,
  input  logic [N_PORTS*IDX_W-1:0]    sel_idx_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  output logic [N_PORTS*DATA_W-1:0]   out_data_o
);

  logic [DATA_W-1:0] lane [N_PORTS];

  generate
    for (genvar i = 0; i < int'(N_PORTS); i++) begin : g_lane
      assign lane[i] = st_data_i[i*DATA_W +: DATA_W];
    end

    for (genvar o = 0; o < int'(N_PORTS); o++) begin : g_out
      logic [IDX_W-1:0] src;
      logic             hit;
      assign src = sel_idx_i[o*IDX_W +: IDX_W];
      assign hit = sel_vld_i[o] & st_valid_i[src];
      assign out_valid_o[o]                 = hit;
      assign out_data_o[o*DATA_W +: DATA_W] = hit ? lane[src] : '0;
    end
  endgenerate

endmodule

// File: rtl/tdm_gt_router.sv
module tdm_gt_router
  import gt_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SLOTS   = 8,
  localparam int unsigned IDX_W  = idx_width(N_PORTS),
  localparam int unsigned SLOT_W = idx_width(SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  input  logic [N_PORTS*DATA_W-1:0]   in_data_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  output logic [N_PORTS*DATA_W-1:0]   out_data_o,
  output logic [SLOT_W-1:0]           slot_o,
  input  logic                        cfg_we_i,
  input  logic [SLOT_W-1:0]           cfg_slot_i,
  input  logic [IDX_W-1:0]            cfg_out_i,
  input  logic [IDX_W-1:0]            cfg_in_i,
  input  logic                        cfg_en_i,
  output logic                        cfg_err_o
);

  logic [SLOT_W-1:0]          slot;
  logic [N_PORTS-1:0]         st_valid;
  logic [N_PORTS*DATA_W-1:0]  st_data;
  logic [SLOT_W-1:0]          st_slot;
  logic [N_PORTS-1:0]         sel_vld;
  logic [N_PORTS*IDX_W-1:0]   sel_idx;

  gt_slot_counter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot)
  );

  gt_in_stage #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .slot_i     (slot),
    .st_valid_o (st_valid),
    .st_data_o  (st_data),
    .st_slot_o  (st_slot)
  );

  gt_slot_table #(.N_PORTS(N_PORTS), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_slot_i (cfg_slot_i),
    .wr_out_i  (cfg_out_i),
    .wr_in_i   (cfg_in_i),
    .wr_set_i  (cfg_en_i),
    .wr_err_o  (cfg_err_o),
    .rd_slot_i (st_slot),
    .rd_vld_o  (sel_vld),
    .rd_idx_o  (sel_idx)
  );

  gt_xbar #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_xbar (
    .st_valid_i  (st_valid),
    .st_data_i   (st_data),
    .sel_vld_i   (sel_vld),
    .sel_idx_i   (sel_idx),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  assign slot_o = slot;

endmodule

// File: rtl/tdm_gt_router_chk.sv
module tdm_gt_router_chk #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned SLOT_W  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_PORTS-1:0]         in_valid_i,
  input logic [N_PORTS-1:0]         out_valid_o,
  input logic [N_PORTS*DATA_W-1:0]  out_data_o,
  input logic [SLOT_W-1:0]          slot_o,
  input logic                       cfg_we_i,
  input logic                       cfg_en_i,
  input logic                       cfg_err_o
);

  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(SLOTS - 1);

  p_slot_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != LastSlot) |=> (slot_o == $past(slot_o) + 1'b1));

  p_slot_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o == LastSlot) |=> (slot_o == '0));

  p_src_seen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_valid_o) |-> $past(|in_valid_i));

  generate
    for (genvar o = 0; o < int'(N_PORTS); o++) begin : g_idle
      p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_valid_o[o] |-> (out_data_o[o*DATA_W +: DATA_W] == '0));
    end
  endgenerate

  p_err_needs_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_we_i && cfg_en_i));

  p_clear_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_en_i) |=> !cfg_err_o);

endmodule

bind tdm_gt_router tdm_gt_router_chk #(
  .N_PORTS(N_PORTS), .DATA_W(DATA_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .slot_o      (slot_o),
  .cfg_we_i    (cfg_we_i),
  .cfg_en_i    (cfg_en_i),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_tdm_gt_router.sv
`timescale 1ns/1ps
module sim_tdm_gt_router;

  localparam int NP = 4;
  localparam int DW = 16;
  localparam int NS = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP*DW-1:0]  in_data = '0;
  logic [NP-1:0]     out_valid;
  logic [NP*DW-1:0]  out_data;
  logic [2:0]        slot;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_slot = '0;
  logic [1:0]        cfg_out = '0;
  logic [1:0]        cfg_in = '0;
  logic              cfg_en = 1'b0;
  logic              cfg_err;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  bit          rv [NS][NP];
  int          ri [NS][NP];
  bit [NP-1:0] pv = '0;
  logic [DW-1:0] pd [NP];
  int          pslot = 0;
  int          bslot = 0;

  always #2.5 clk = ~clk;

  tdm_gt_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .slot_o(slot),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_out_i(cfg_out),
    .cfg_in_i(cfg_in), .cfg_en_i(cfg_en), .cfg_err_o(cfg_err)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bslot <= 0;
    else        bslot <= (bslot + 1) % NS;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int s, input int o, input int i, input bit en,
                           input string req);
    bit exp_err;
    exp_err = en && rv[s][o] && (ri[s][o] != i);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(s); cfg_out = 2'(o); cfg_in = 2'(i); cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_err == exp_err, req, "cfg_err after write", cfg_err, exp_err);
    if (!exp_err) begin
      rv[s][o] = en;
      if (en) ri[s][o] = i;
    end
    @(negedge clk);
    chk(cfg_err == 1'b0, "R10", "cfg_err idle", cfg_err, 0);
  endtask

  task automatic traffic(input int seed, input int ncyc, input string req);
    for (int k = 0; k <= ncyc; k++) begin
      @(negedge clk);
      chk(slot == 3'(bslot), "R1", "slot count", slot, bslot);
      for (int o = 0; o < NP; o++) begin
        bit            ev;
        logic [DW-1:0] ed;
        ev = rv[pslot][o] && pv[ri[pslot][o]];
        ed = ev ? pd[ri[pslot][o]] : '0;
        chk(out_valid[o] == ev, req, $sformatf("valid out%0d slot%0d", o, pslot),
            out_valid[o], ev);
        chk(out_data[o*DW +: DW] == ed, req, $sformatf("data out%0d slot%0d", o, pslot),
            out_data[o*DW +: DW], ed);
      end
      for (int i = 0; i < NP; i++) begin
        pv[i] = (k < ncyc) && (((k + i + seed) % 3) != 0);
        pd[i] = DW'(seed * 911 + k * 37 + i * 5 + 1);
        in_valid[i] = pv[i];
        in_data[i*DW +: DW] = pd[i];
      end
      pslot = bslot;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog run did not finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < NP; o++) begin rv[s][o] = 0; ri[s][o] = 0; end
    for (int i = 0; i < NP; i++) pd[i] = '0;
    in_valid = '1;
    in_data  = {NP{16'hA5A5}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(slot == 3'd0, "R1", "slot in reset", slot, 0);
    chk(out_valid == '0, "R9", "valid in reset", out_valid, 0);
    chk(out_data == '0, "R9", "data in reset", out_data, 0);
    chk(cfg_err == 1'b0, "R10", "err in reset", cfg_err, 0);
    in_valid = '0;
    in_data  = '0;
    rst_n = 1'b1;

    // R9: empty schedule keeps every output idle
    traffic(1, 12, "R9");

    // R5: rotating permutation in every slot
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < NP; o++) cfg_write(s, o, (o + s) % NP, 1'b1, "R5");
    traffic(2, 24, "R2/R4");

    // R6: conflicting write refused, route unchanged; R5 same-input rewrite accepted
    cfg_write(3, 1, (1 + 3 + 1) % NP, 1'b1, "R6");
    cfg_write(3, 1, (1 + 3) % NP, 1'b1, "R5");
    traffic(3, 16, "R6");

    // R7/R3: clear one entry, output idles in the following slot
    cfg_write(5, 2, 0, 1'b0, "R7");
    traffic(4, 16, "R3");
    cfg_write(5, 2, 3, 1'b1, "R5");
    traffic(5, 16, "R2");

    // R8: input 3 feeds all outputs in slot 2
    for (int o = 0; o < NP; o++) cfg_write(2, o, 0, 1'b0, "R7");
    for (int o = 0; o < NP; o++) cfg_write(2, o, 3, 1'b1, "R8");
    traffic(6, 16, "R8");

    // R6 sweep: every occupied entry refuses a different input
    for (int s = 0; s < NS; s++)
      for (int o = 0; o < NP; o++)
        cfg_write(s, o, (ri[s][o] + 1) % NP, 1'b1, "R6");
    traffic(7, 24, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule